// File: doc/BRIEF.md
# DRAM Read/Write Request Scheduler

This block is the front end of a single-channel DRAM controller. It accepts memory requests on a valid/ready port and splits each address into rank, bank and row. Reads and writes wait in separate queues, and the block offers one command descriptor at a time to a downstream timing engine. Command sequencing, refresh and the data path belong to that engine.

Reads are served by default. When the write queue holds more entries than a threshold, read issue stops. After a fixed read-to-write turnaround gap, the queued writes are issued until the write queue is empty, and then reads resume. A read whose address matches a queued write is answered from that write and never enters the read queue. An input selects the policy: plain oldest-first, or oldest row hit first. Row hits are judged against a per-bank table of open rows, which every grant updates.

Top module: `dram_req_sched`

## Requirements
- R1: A write is accepted (`req_ready` high while `req_write` is high) exactly when fewer than WR_DEPTH writes are queued. When the write queue is full, the write is refused and must be retried.
- R2: A read is accepted exactly when the queued reads plus the granted reads not yet retired number fewer than RD_DEPTH. Each `rd_retire` pulse frees one granted read. A pulse is ignored when no granted read is outstanding.
- R3: An accepted read whose address equals any write queued at the start of that cycle, including a write granted in the same cycle, raises `fwd_valid` with that address on the next cycle. Such a read is never queued or issued.
- R4: A read command (`cmd_write` low) is offered only in read mode. A write command (`cmd_write` high) is offered only in drain mode.
- R5: If more than floor(WR_DEPTH*WR_THRESH_PCT/100) writes are queued at a clock edge in read mode, no read is offered after that edge. Exactly TWTR cycles follow with `cmd_valid` low, and then writes are offered.
- R6: In drain mode, the cycle in which the write queue is empty is followed by a return to read mode at the next edge.
- R7: With `rowhit_first` low, the offered command is the oldest entry of the active queue.
- R8: With `rowhit_first` high, the offered command is the oldest entry of the active queue whose row is open in its bank. If no entry has its row open, the oldest entry is offered.
- R9: After reset no bank has an open row. Each grant marks the granted row as open in its rank/bank. `cmd_row_hit` reports whether the offered entry's row is open.
- R10: The address layout is: bits [3:0] line offset, bit [4] rank, bits [6:5] bank, bits [15:7] row. These positions apply at the default widths. `cmd_rank`, `cmd_bank` and `cmd_row` carry these fields of `cmd_addr`.
- R11: During and right after reset, `cmd_valid` and `fwd_valid` are low and `req_ready` is high for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rowhit_first | input | 1 | 1: prefer open-row hits, 0: oldest first |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | AW | Request byte address |
| req_ready | output | 1 | Request accepted this cycle if valid |
| fwd_valid | output | 1 | Read answered from a pending write |
| fwd_addr | output | AW | Address of the answered read |
| cmd_valid | output | 1 | Command descriptor offered |
| cmd_ready | input | 1 | Downstream takes the offered command |
| cmd_write | output | 1 | Offered command is a write |
| cmd_addr | output | AW | Full address of the offered command |
| cmd_rank | output | RANK_W | Rank field |
| cmd_bank | output | BANK_W | Bank field |
| cmd_row | output | ROW_W | Row field |
| cmd_row_hit | output | 1 | Offered row already open in its bank |
| rd_retire | input | 1 | One granted read has completed |

## Verification
Two functions can fall in the same cycle. In the first, a read arrives whose address matches the write being granted in that same cycle. The bench provokes this by presenting the same read address on every cycle while a drain runs. The reference model judges the match against the write queue as it stood before the grant, so that read must be forwarded, while identical reads after the write has left must be queued. In the second, a write that pushes the occupancy over the threshold lands in the same cycle as a read grant. The model expects that read grant to complete, followed by exactly TWTR silent cycles.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_TURN  = 2'd1,
    MD_DRAIN = 2'd2
  } sched_mode_e;

  // occupancy above which the write queue forces a drain
  function automatic int wr_drain_level(int depth, int pct);
    return (depth * pct) / 100;
  endfunction

endpackage

// File: rtl/dram_sched_queue.sv
// Age-ordered queue: slot 0 is the oldest, removal compacts the tail.
module dram_sched_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  input  logic [IW-1:0] pop_idx,
  output logic [AW-1:0] slot [DEPTH],
  output logic [DEPTH-1:0] vld,
  output logic [CW-1:0] count
);

  logic [AW-1:0] nxt [DEPTH];
  int wpos;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) nxt[i] = slot[i];
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (i >= int'(pop_idx)) nxt[i] = slot[i+1];
    end
    wpos = int'(count) - (pop ? 1 : 0);
    if (push) begin
      for (int i = 0; i < DEPTH; i++)
        if (i == wpos) nxt[i] = push_addr;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot[i] <= nxt[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + CW'(push) - CW'(pop);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) vld[i] = (i < int'(count));
  end

endmodule

// File: rtl/dram_open_rows.sv
// Per rank/bank open-row table, invalid after reset.
module dram_open_rows #(
  parameter int RB_W  = 3,
  parameter int ROW_W = 9,
  localparam int NB   = 1 << RB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [RB_W-1:0]  upd_bank,
  input  logic [ROW_W-1:0] upd_row,
  output logic [ROW_W-1:0] row_tab [NB],
  output logic [NB-1:0]    row_ok
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_ok <= '0;
      for (int i = 0; i < NB; i++) row_tab[i] <= '1;
    end else if (upd) begin
      row_ok[upd_bank]  <= 1'b1;
      row_tab[upd_bank] <= upd_row;
    end
  end

endmodule

// File: rtl/dram_pick.sv
// Chooses the oldest entry, or the oldest open-row hit when asked.
module dram_pick #(
  parameter int DEPTH = 4,
  parameter int RB_W  = 3,
  parameter int ROW_W = 9,
  localparam int NB   = 1 << RB_W,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [RB_W-1:0]  bidx [DEPTH],
  input  logic [ROW_W-1:0] brow [DEPTH],
  input  logic [DEPTH-1:0] vld,
  input  logic [ROW_W-1:0] row_tab [NB],
  input  logic [NB-1:0]    row_ok,
  input  logic             rowhit_first,
  output logic             found,
  output logic [IW-1:0]    idx,
  output logic             hit
);

  logic [DEPTH-1:0] entry_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign entry_hit[g] = row_ok[bidx[g]] && (row_tab[bidx[g]] == brow[g]);
  end

  logic          any_hit;
  logic [IW-1:0] oldest, oldest_hit;

  always_comb begin
    found      = 1'b0;
    any_hit    = 1'b0;
    oldest     = '0;
    oldest_hit = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld[i]) begin
        found  = 1'b1;
        oldest = IW'(i);
        if (entry_hit[i]) begin
          any_hit    = 1'b1;
          oldest_hit = IW'(i);
        end
      end
    end
    idx = (rowhit_first && any_hit) ? oldest_hit : oldest;
    hit = entry_hit[idx];
  end

endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
  import dram_sched_pkg::*;
#(
  parameter int AW            = 16,
  parameter int COL_W         = 4,
  parameter int RANK_W        = 1,
  parameter int BANK_W        = 2,
  parameter int RD_DEPTH      = 4,
  parameter int WR_DEPTH      = 4,
  parameter int WR_THRESH_PCT = 50,
  parameter int TWTR          = 3,
  localparam int ROW_W        = AW - COL_W - RANK_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rowhit_first,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  output logic              req_ready,
  output logic              fwd_valid,
  output logic [AW-1:0]     fwd_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [AW-1:0]     cmd_addr,
  output logic [RANK_W-1:0] cmd_rank,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              cmd_row_hit,
  input  logic              rd_retire
);

  localparam int RB_W      = RANK_W + BANK_W;
  localparam int NB        = 1 << RB_W;
  localparam int RD_IW     = $clog2(RD_DEPTH);
  localparam int RD_CW     = $clog2(RD_DEPTH + 1);
  localparam int WR_IW     = $clog2(WR_DEPTH);
  localparam int WR_CW     = $clog2(WR_DEPTH + 1);
  localparam int WR_THRESH = wr_drain_level(WR_DEPTH, WR_THRESH_PCT);
  localparam int TC_W      = $clog2(TWTR + 1);

  // queue state
  logic [AW-1:0]       rd_slot [RD_DEPTH];
  logic [RD_DEPTH-1:0] rd_vld;
  logic [RD_CW-1:0]    rd_cnt;
  logic [AW-1:0]       wr_slot [WR_DEPTH];
  logic [WR_DEPTH-1:0] wr_vld;
  logic [WR_CW-1:0]    wr_cnt;

  // named events
  logic fwd_match, rd_space, wr_space, accept;
  logic rd_push, wr_push, fwd_evt, grant, rd_pop, wr_pop, retire_evt;

  sched_mode_e      mode;
  logic [TC_W-1:0]  turn_cnt;
  logic [RD_CW-1:0] rd_pend;

  always_comb begin
    fwd_match = 1'b0;
    for (int i = 0; i < WR_DEPTH; i++)
      if (wr_vld[i] && wr_slot[i] == req_addr) fwd_match = 1'b1;
  end

  assign rd_space   = (int'(rd_cnt) + int'(rd_pend)) < RD_DEPTH;
  assign wr_space   = int'(wr_cnt) < WR_DEPTH;
  assign req_ready  = req_write ? wr_space : rd_space;
  assign accept     = req_valid && req_ready;
  assign wr_push    = accept && req_write;
  assign fwd_evt    = accept && !req_write && fwd_match;
  assign rd_push    = accept && !req_write && !fwd_match;
  assign grant      = cmd_valid && cmd_ready;
  assign rd_pop     = grant && !cmd_write;
  assign wr_pop     = grant && cmd_write;
  assign retire_evt = rd_retire && (rd_pend != '0);

  // per-slot address fields for the pickers
  logic [RB_W-1:0]  rd_bi [RD_DEPTH];
  logic [ROW_W-1:0] rd_rw [RD_DEPTH];
  logic [RB_W-1:0]  wr_bi [WR_DEPTH];
  logic [ROW_W-1:0] wr_rw [WR_DEPTH];

  for (genvar g = 0; g < RD_DEPTH; g++) begin : g_rd_fld
    assign rd_bi[g] = rd_slot[g][COL_W +: RB_W];
    assign rd_rw[g] = rd_slot[g][AW-1 -: ROW_W];
  end
  for (genvar g = 0; g < WR_DEPTH; g++) begin : g_wr_fld
    assign wr_bi[g] = wr_slot[g][COL_W +: RB_W];
    assign wr_rw[g] = wr_slot[g][AW-1 -: ROW_W];
  end

  logic [ROW_W-1:0] row_tab [NB];
  logic [NB-1:0]    row_ok;
  logic             rd_found, rd_hit, wr_found, wr_hit;
  logic [RD_IW-1:0] rd_idx;
  logic [WR_IW-1:0] wr_idx;

  dram_sched_queue #(.DEPTH(RD_DEPTH), .AW(AW)) u_rdq (
    .clk(clk), .rst_n(rst_n), .push(rd_push), .push_addr(req_addr),
    .pop(rd_pop), .pop_idx(rd_idx), .slot(rd_slot), .vld(rd_vld), .count(rd_cnt));

  dram_sched_queue #(.DEPTH(WR_DEPTH), .AW(AW)) u_wrq (
    .clk(clk), .rst_n(rst_n), .push(wr_push), .push_addr(req_addr),
    .pop(wr_pop), .pop_idx(wr_idx), .slot(wr_slot), .vld(wr_vld), .count(wr_cnt));

  dram_pick #(.DEPTH(RD_DEPTH), .RB_W(RB_W), .ROW_W(ROW_W)) u_rd_pick (
    .bidx(rd_bi), .brow(rd_rw), .vld(rd_vld), .row_tab(row_tab), .row_ok(row_ok),
    .rowhit_first(rowhit_first), .found(rd_found), .idx(rd_idx), .hit(rd_hit));

  dram_pick #(.DEPTH(WR_DEPTH), .RB_W(RB_W), .ROW_W(ROW_W)) u_wr_pick (
    .bidx(wr_bi), .brow(wr_rw), .vld(wr_vld), .row_tab(row_tab), .row_ok(row_ok),
    .rowhit_first(rowhit_first), .found(wr_found), .idx(wr_idx), .hit(wr_hit));

  dram_open_rows #(.RB_W(RB_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .upd(grant), .upd_bank(cmd_addr[COL_W +: RB_W]),
    .upd_row(cmd_row), .row_tab(row_tab), .row_ok(row_ok));

  // command offer
  always_comb begin
    if (mode == MD_DRAIN) begin
      cmd_valid   = wr_found;
      cmd_write   = 1'b1;
      cmd_addr    = wr_slot[wr_idx];
      cmd_row_hit = wr_hit;
    end else begin
      cmd_valid   = (mode == MD_READ) && rd_found;
      cmd_write   = 1'b0;
      cmd_addr    = rd_slot[rd_idx];
      cmd_row_hit = rd_hit;
    end
  end

  assign cmd_rank = cmd_addr[COL_W +: RANK_W];
  assign cmd_bank = cmd_addr[COL_W + RANK_W +: BANK_W];
  assign cmd_row  = cmd_addr[AW-1 -: ROW_W];

  // read / turnaround / drain sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MD_READ;
      turn_cnt <= '0;
    end else begin
      unique case (mode)
        MD_READ:
          if (int'(wr_cnt) > WR_THRESH) begin
            mode     <= MD_TURN;
            turn_cnt <= TC_W'(TWTR);
          end
        MD_TURN:
          if (turn_cnt == TC_W'(1)) mode <= MD_DRAIN;
          else                      turn_cnt <= turn_cnt - TC_W'(1);
        MD_DRAIN:
          if (wr_cnt == '0) mode <= MD_READ;
        default: mode <= MD_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= '0;
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
    end else begin
      rd_pend   <= rd_pend + RD_CW'(rd_pop) - RD_CW'(retire_evt);
      fwd_valid <= fwd_evt;
      if (fwd_evt) fwd_addr <= req_addr;
    end
  end

endmodule

// File: rtl/dram_req_sched_chk.sv
module dram_req_sched_chk
  import dram_sched_pkg::*;
#(
  parameter int RD_DEPTH  = 4,
  parameter int WR_DEPTH  = 4,
  parameter int WR_THRESH = 2,
  localparam int RD_CW    = $clog2(RD_DEPTH + 1),
  localparam int WR_CW    = $clog2(WR_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_write,
  input sched_mode_e      mode,
  input logic [RD_CW-1:0] rd_cnt,
  input logic [RD_CW-1:0] rd_pend,
  input logic [WR_CW-1:0] wr_cnt,
  input logic             fwd_evt
);

  AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_cnt) <= WR_DEPTH); // R1

  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_cnt) + int'(rd_pend)) <= RD_DEPTH); // R2

  AST_READ_GRANT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_write) |=> (rd_pend != '0)); // R2

  AST_FWD_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_evt |=> (rd_cnt <= $past(rd_cnt))); // R3

  AST_ENTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_READ && int'(wr_cnt) > WR_THRESH) |=> (mode == MD_TURN)); // R5

  AST_TURN_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_TURN) |=> (mode != MD_READ)); // R5

  AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_DRAIN && wr_cnt == '0) |=> (mode == MD_READ)); // R6

endmodule

bind dram_req_sched dram_req_sched_chk #(
  .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .WR_THRESH(WR_THRESH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .mode(mode), .rd_cnt(rd_cnt), .rd_pend(rd_pend),
  .wr_cnt(wr_cnt), .fwd_evt(fwd_evt)
);

// File: tb/dram_req_sched_test.sv
`timescale 1ns/1ps
module dram_req_sched_test;

  localparam int RDD  = 4;
  localparam int WRD  = 4;
  localparam int THR  = (WRD * 50) / 100;
  localparam int TURN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rowhit_first = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, fwd_valid, cmd_valid, cmd_write, cmd_row_hit;
  logic [15:0] fwd_addr, cmd_addr;
  logic        cmd_ready = 1'b0, rd_retire = 1'b0;
  logic [0:0]  cmd_rank;
  logic [1:0]  cmd_bank;
  logic [8:0]  cmd_row;

  always #5 clk = ~clk;

  dram_req_sched uut (
    .clk(clk), .rst_n(rst_n), .rowhit_first(rowhit_first),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_row_hit(cmd_row_hit),
    .rd_retire(rd_retire));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] mrd[$];
  logic [15:0] mwr[$];
  int          mpend = 0, mmode = 0, mtc = 0;
  logic [8:0]  mrow [8];
  bit          mok  [8];
  bit          efwd = 1'b0;
  logic [15:0] efwd_addr = '0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(int row, int bank, int rank, int col);
    return 16'((row << 7) | (bank << 5) | (rank << 4) | col);
  endfunction

  function automatic bit is_open(logic [15:0] a);
    int k = int'(a[6:4]);
    return mok[k] && (mrow[k] == a[15:7]);
  endfunction

  task automatic step(input bit v, input bit w, input logic [15:0] a,
                      input bit cr, input bit rt, input bit pol);
    logic [15:0] q[$];
    int  sel, old_wr;
    bit  rdy, acc, match, gnt;
    @(posedge clk);
    #1;
    req_valid = v; req_write = w; req_addr = a;
    cmd_ready = cr; rd_retire = rt; rowhit_first = pol;
    @(negedge clk);
    // expected offer
    q.delete();
    if (mmode == 0) q = mrd;
    else if (mmode == 2) q = mwr;
    sel = -1;
    if (q.size() > 0) begin
      sel = 0;
      if (pol) begin
        for (int i = 0; i < q.size(); i++)
          if (is_open(q[i])) begin sel = i; break; end
      end
    end
    rdy = w ? (mwr.size() < WRD) : ((mrd.size() + mpend) < RDD);
    chk(w ? "R1" : "R2", "req_ready", 32'(req_ready), 32'(rdy));
    chk("R5/R6", "cmd_valid", 32'(cmd_valid), 32'(sel >= 0));
    if (sel >= 0) begin
      chk(pol ? "R8" : "R7", "cmd_addr", 32'(cmd_addr), 32'(q[sel]));
      chk("R4", "cmd_write", 32'(cmd_write), 32'(mmode == 2));
      chk("R10", "cmd_rank", 32'(cmd_rank), (32'(q[sel]) >> 4) & 1);
      chk("R10", "cmd_bank", 32'(cmd_bank), (32'(q[sel]) >> 5) & 3);
      chk("R10", "cmd_row", 32'(cmd_row), 32'(q[sel]) >> 7);
      chk("R9", "cmd_row_hit", 32'(cmd_row_hit), 32'(is_open(q[sel])));
    end
    chk("R3", "fwd_valid", 32'(fwd_valid), 32'(efwd));
    if (efwd) chk("R3", "fwd_addr", 32'(fwd_addr), 32'(efwd_addr));
    // advance reference
    old_wr = mwr.size();
    acc   = v && rdy;
    match = 1'b0;
    if (acc && !w) foreach (mwr[i]) if (mwr[i] == a) match = 1'b1;
    gnt = (sel >= 0) && cr;
    if (rt && mpend > 0) mpend--;
    if (gnt) begin
      mrow[int'(q[sel][6:4])] = q[sel][15:7];
      mok[int'(q[sel][6:4])]  = 1'b1;
      if (mmode == 0) begin mrd.delete(sel); mpend++; end
      else mwr.delete(sel);
    end
    if (acc && w) mwr.push_back(a);
    else if (acc && !match) mrd.push_back(a);
    efwd = match;
    efwd_addr = a;
    case (mmode)
      0: if (old_wr > THR) begin mmode = 1; mtc = TURN; end
      1: if (mtc == 1) mmode = 2; else mtc--;
      default: if (old_wr == 0) mmode = 0;
    endcase
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    foreach (mok[i]) begin mok[i] = 1'b0; mrow[i] = '1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs while reset is held
    chk("R11", "cmd_valid in reset", 32'(cmd_valid), 0);
    chk("R11", "fwd_valid in reset", 32'(fwd_valid), 0);
    chk("R11", "read ready in reset", 32'(req_ready), 1);
    req_write = 1'b1;
    #1 chk("R11", "write ready in reset", 32'(req_ready), 1);
    req_write = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 / R7: fill reads with the consumer stalled, one refused
    step(1, 0, mk(1, 0, 0, 0), 0, 0, 0);
    step(1, 0, mk(2, 1, 1, 0), 0, 0, 0);
    step(1, 0, mk(1, 0, 0, 1), 0, 0, 0);
    step(1, 0, mk(3, 2, 0, 0), 0, 0, 0);
    step(1, 0, mk(4, 3, 0, 0), 0, 0, 0);
    repeat (5) step(1, 0, mk(5, 0, 0, 0), 1, 0, 0);
    repeat (6) step(0, 0, 0, 0, 1, 0);

    // R3 / R5 / R6: two writes stay below the threshold, a read forwards
    step(1, 1, mk(3, 2, 0, 0), 0, 0, 0);
    step(1, 1, mk(4, 3, 1, 0), 0, 0, 0);
    step(1, 0, mk(3, 2, 0, 0), 0, 0, 0);
    step(1, 1, mk(5, 0, 0, 0), 1, 0, 0);
    // same read presented while the drain grants the matching write
    repeat (12) step(1, 0, mk(3, 2, 0, 0), 1, 1, 0);
    repeat (6) step(0, 0, 0, 1, 1, 0);

    // R8 / R9: open row in bank 0 is row 5, queue a miss ahead of a hit
    step(1, 0, mk(7, 0, 0, 0), 0, 0, 1);
    step(1, 0, mk(5, 0, 0, 2), 0, 0, 1);
    repeat (4) step(0, 0, 0, 1, 1, 1);

    // mixed traffic under both policies
    for (int ph = 0; ph < 2; ph++) begin
      for (int n = 0; n < 2000; n++) begin
        step(($urandom % 4) != 0, ($urandom % 3) == 0,
             mk($urandom % 3, $urandom % 4, $urandom % 2, $urandom % 2),
             ($urandom % 4) != 0, ($urandom % 3) == 0, ph == 1);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule